// File: doc/BRIEF.md
# Processor Exception Arbiter

This block sits beside the completion stage of a simple in-order core. It gathers every reason the core may have to leave its normal instruction stream. The synchronous reasons come from the instruction that completes in the current cycle: a fetch fault, a program fault, a misaligned access or a data-access fault. The asynchronous reasons are an external interrupt level and a timer whose top bit has just turned on. The block decides which reason wins and when it is taken. It then emits a one-cycle take strobe together with a 20-bit handler offset and, for program faults, a set of cause bits for the handler to read.

Synchronous faults are taken on the cycle after the faulting instruction completes. An asynchronous request first holds back dispatch and waits for the pipeline to empty. Any fault raised by an instruction still in flight beats the pending request. Taking any exception clears the interrupt-enable state bit, which masks both asynchronous sources until the core sets it again through `eeSet`.

Top module: `excArbiter`

## Requirements
- R1: On a taken exception, `excVector` is 0x00400 for a fetch fault, 0x00700 for a program fault, 0x00600 for a misaligned access, 0x00300 for a data-access fault, 0x00500 for the external interrupt and 0x00900 for the timer.
- R2: A synchronous fault is taken only when `instDone` is high. It is taken on the clock edge that samples it, so the strobe appears in the next cycle. Among the faults of one instruction the order is fetch, then program, then misaligned, then data access.
- R3: `excCause` bit 0 marks a floating-point enabled fault, bit 1 an illegal opcode, bit 2 a privilege violation and bit 3 a trap. Every program cause present is recorded together. `excCause` is 0 for any non-program exception.
- R4: A floating-point enabled fault is raised when `fpOp`, `fpSummary` and at least one bit of `fpModeEn` are all high.
- R5: A privilege fault needs `userMode` high together with either `privOp`, or `sprMove` with `sprNumMsb` set. With `userMode` low, these inputs raise nothing.
- R6: When `intEnable` is high and `extIrq` is high, `dispatchStall` rises in the next cycle. No take happens while `pipeEmpty` is low. The interrupt is taken on the edge that samples `pipeEmpty` high.
- R7: A synchronous fault sampled in the same cycle as a takeable asynchronous request wins, and the asynchronous request is not taken.
- R8: The timer request becomes pending when bit DEC_W-1 of `decValue` goes from 0 to 1. It stays pending while `intEnable` is low. A top bit that simply stays high does not raise it again. The external interrupt ranks above the timer.
- R9: The pending timer request is cleared only when the timer exception itself is taken. Taking the external interrupt leaves it pending.
- R10: Every take clears `intEnable` on the same edge that raises `takeExc`, even if `eeSet` is high then. Otherwise `eeSet` sets `intEnable` on the next edge.
- R11: `takeExc` lasts one cycle, and `dispatchStall` is high during it. `dispatchStall` is low in the cycle after the strobe.
- R12: The offset 0x00800 is never produced.
- R13: Fault flags presented in the strobe cycle are ignored.
- R14: After reset, `takeExc`, `dispatchStall`, `intEnable`, `excVector` and `excCause` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instDone | input | 1 | An instruction completes this cycle; qualifies its fault flags |
| fetchFault | input | 1 | Completing instruction had a fetch fault |
| illegalOp | input | 1 | Completing instruction had an illegal opcode combination |
| privOp | input | 1 | Completing instruction is privileged |
| sprMove | input | 1 | Completing instruction moves a special register |
| sprNumMsb | input | 1 | Top bit of that special-register number |
| trapHit | input | 1 | A trap condition of the completing instruction is met |
| fpOp | input | 1 | Completing instruction updates floating-point status |
| userMode | input | 1 | Privilege state bit, 1 = user |
| fpModeEn | input | 2 | Floating-point exception-mode enables |
| fpSummary | input | 1 | Floating-point enabled-exception summary flag |
| alignFault | input | 1 | Completing instruction made a misaligned access |
| dataFault | input | 1 | Completing instruction had a data-access fault |
| pipeEmpty | input | 1 | No dispatched instruction remains uncompleted |
| extIrq | input | 1 | External interrupt level |
| eeSet | input | 1 | Sets the interrupt-enable state bit |
| decValue | input | DEC_W | Timer value |
| dispatchStall | output | 1 | Holds back instruction dispatch |
| takeExc | output | 1 | One-cycle take strobe |
| excVector | output | 20 | Handler offset |
| excCause | output | 4 | Program-fault cause bits |
| intEnable | output | 1 | Interrupt-enable state bit |

## Verification
The collision that matters is a synchronous fault that completes in the same cycle in which an asynchronous request becomes takeable. Two cases provoke it. In the first, the drain finishes: `pipeEmpty` rises while an in-flight instruction reports a misaligned access. In the second, the block is idle and a data fault arrives together with a fresh external interrupt. Each case is judged by the offset on the strobe. A second strobe must not follow, because the take has already cleared `intEnable` and so masks the interrupt. A sweep over every fault combination also checks the priority and the cause bits against values computed in the bench.

// File: rtl/excPkg.sv
package excPkg;
  localparam int VEC_W   = 20;
  localparam int CAUSE_W = 4;
  localparam int SYNC_N  = 4;

  localparam int CAUSE_FP      = 0;
  localparam int CAUSE_ILLEGAL = 1;
  localparam int CAUSE_PRIV    = 2;
  localparam int CAUSE_TRAP    = 3;

  localparam logic [VEC_W-1:0] VEC_DATA  = 20'h00300;
  localparam logic [VEC_W-1:0] VEC_FETCH = 20'h00400;
  localparam logic [VEC_W-1:0] VEC_EXT   = 20'h00500;
  localparam logic [VEC_W-1:0] VEC_ALIGN = 20'h00600;
  localparam logic [VEC_W-1:0] VEC_PROG  = 20'h00700;
  localparam logic [VEC_W-1:0] VEC_TIMER = 20'h00900;

  // slot order is priority order, slot 0 highest
  function automatic logic [VEC_W-1:0] syncSlotVec(input int slot);
    case (slot)
      0:       return VEC_FETCH;
      1:       return VEC_PROG;
      2:       return VEC_ALIGN;
      default: return VEC_DATA;
    endcase
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_TAKE  = 2'd2
  } arbState_t;

  typedef struct packed {
    logic loadSync;
    logic loadAsync;
  } ctrlStrobe_t;
endpackage

// File: rtl/excProgDecode.sv
module excProgDecode
  import excPkg::*;
(
  input  logic               illegalOp,
  input  logic               privOp,
  input  logic               sprMove,
  input  logic               sprNumMsb,
  input  logic               trapHit,
  input  logic               fpOp,
  input  logic               userMode,
  input  logic [1:0]         fpModeEn,
  input  logic               fpSummary,
  output logic [CAUSE_W-1:0] progCause
);
  logic fpEnabledFault;
  logic privFault;

  always_comb begin
    fpEnabledFault = fpOp & fpSummary & (|fpModeEn);
    privFault      = userMode & (privOp | (sprMove & sprNumMsb));
    progCause                = '0;
    progCause[CAUSE_FP]      = fpEnabledFault;
    progCause[CAUSE_ILLEGAL] = illegalOp;
    progCause[CAUSE_PRIV]    = privFault;
    progCause[CAUSE_TRAP]    = trapHit;
  end
endmodule

// File: rtl/excDatapath.sv
module excDatapath
  import excPkg::*;
#(
  parameter int DEC_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instDone,
  input  logic               fetchFault,
  input  logic               illegalOp,
  input  logic               privOp,
  input  logic               sprMove,
  input  logic               sprNumMsb,
  input  logic               trapHit,
  input  logic               fpOp,
  input  logic               userMode,
  input  logic [1:0]         fpModeEn,
  input  logic               fpSummary,
  input  logic               alignFault,
  input  logic               dataFault,
  input  logic               extIrq,
  input  logic               eeSet,
  input  logic [DEC_W-1:0]   decValue,
  input  ctrlStrobe_t        strobe,
  output logic               syncHit,
  output logic               asyncReq,
  output logic [VEC_W-1:0]   excVector,
  output logic [CAUSE_W-1:0] excCause,
  output logic               intEnable
);
  localparam int MSB = DEC_W - 1;

  logic [CAUSE_W-1:0] progCause;
  logic [SYNC_N-1:0]  syncFlags;
  logic [VEC_W-1:0]   syncVec;
  logic [CAUSE_W-1:0] syncCause;
  logic               prevMsb;
  logic               decPending;
  logic               decRise;
  logic               takeTimer;
  logic               takeAny;

  excProgDecode uDecode (
    .illegalOp (illegalOp),
    .privOp    (privOp),
    .sprMove   (sprMove),
    .sprNumMsb (sprNumMsb),
    .trapHit   (trapHit),
    .fpOp      (fpOp),
    .userMode  (userMode),
    .fpModeEn  (fpModeEn),
    .fpSummary (fpSummary),
    .progCause (progCause)
  );

  assign syncFlags[0] = fetchFault;
  assign syncFlags[1] = |progCause;
  assign syncFlags[2] = alignFault;
  assign syncFlags[3] = dataFault;

  // fixed-priority pick, scanned from the lowest rank up so slot 0 wins
  always_comb begin
    syncVec   = VEC_DATA;
    syncCause = '0;
    for (int slot = SYNC_N - 1; slot >= 0; slot--) begin
      if (syncFlags[slot]) begin
        syncVec   = syncSlotVec(slot);
        syncCause = (slot == 1) ? progCause : '0;
      end
    end
  end

  assign syncHit   = instDone & (|syncFlags);
  assign decRise   = decValue[MSB] & ~prevMsb;
  assign asyncReq  = intEnable & (extIrq | decPending);
  assign takeTimer = strobe.loadAsync & ~extIrq;
  assign takeAny   = strobe.loadSync | strobe.loadAsync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevMsb    <= 1'b1;
      decPending <= 1'b0;
      intEnable  <= 1'b0;
      excVector  <= '0;
      excCause   <= '0;
    end else begin
      prevMsb    <= decValue[MSB];
      decPending <= (decPending & ~takeTimer) | decRise;
      if (takeAny)    intEnable <= 1'b0;
      else if (eeSet) intEnable <= 1'b1;
      if (strobe.loadSync) begin
        excVector <= syncVec;
        excCause  <= syncCause;
      end else if (strobe.loadAsync) begin
        excVector <= extIrq ? VEC_EXT : VEC_TIMER;
        excCause  <= '0;
      end
    end
  end
endmodule

// File: rtl/excCtrl.sv
module excCtrl
  import excPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncHit,
  input  logic        asyncReq,
  input  logic        pipeEmpty,
  output ctrlStrobe_t strobe,
  output logic        takeExc,
  output logic        dispatchStall
);
  arbState_t state, stateNext;

  always_comb begin
    stateNext        = state;
    strobe           = '0;
    unique case (state)
      ST_IDLE: begin
        if (syncHit) begin
          strobe.loadSync = 1'b1;
          stateNext       = ST_TAKE;
        end else if (asyncReq) begin
          stateNext = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (syncHit) begin
          strobe.loadSync = 1'b1;
          stateNext       = ST_TAKE;
        end else if (!asyncReq) begin
          stateNext = ST_IDLE;
        end else if (pipeEmpty) begin
          strobe.loadAsync = 1'b1;
          stateNext        = ST_TAKE;
        end
      end
      ST_TAKE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign takeExc       = (state == ST_TAKE);
  assign dispatchStall = (state != ST_IDLE);
endmodule

// File: rtl/excArbiter.sv
module excArbiter
  import excPkg::*;
#(
  parameter int DEC_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instDone,
  input  logic               fetchFault,
  input  logic               illegalOp,
  input  logic               privOp,
  input  logic               sprMove,
  input  logic               sprNumMsb,
  input  logic               trapHit,
  input  logic               fpOp,
  input  logic               userMode,
  input  logic [1:0]         fpModeEn,
  input  logic               fpSummary,
  input  logic               alignFault,
  input  logic               dataFault,
  input  logic               pipeEmpty,
  input  logic               extIrq,
  input  logic               eeSet,
  input  logic [DEC_W-1:0]   decValue,
  output logic               dispatchStall,
  output logic               takeExc,
  output logic [VEC_W-1:0]   excVector,
  output logic [CAUSE_W-1:0] excCause,
  output logic               intEnable
);
  ctrlStrobe_t strobe;
  logic        syncHit;
  logic        asyncReq;

  excCtrl uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .syncHit       (syncHit),
    .asyncReq      (asyncReq),
    .pipeEmpty     (pipeEmpty),
    .strobe        (strobe),
    .takeExc       (takeExc),
    .dispatchStall (dispatchStall)
  );

  excDatapath #(.DEC_W(DEC_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .instDone   (instDone),
    .fetchFault (fetchFault),
    .illegalOp  (illegalOp),
    .privOp     (privOp),
    .sprMove    (sprMove),
    .sprNumMsb  (sprNumMsb),
    .trapHit    (trapHit),
    .fpOp       (fpOp),
    .userMode   (userMode),
    .fpModeEn   (fpModeEn),
    .fpSummary  (fpSummary),
    .alignFault (alignFault),
    .dataFault  (dataFault),
    .extIrq     (extIrq),
    .eeSet      (eeSet),
    .decValue   (decValue),
    .strobe     (strobe),
    .syncHit    (syncHit),
    .asyncReq   (asyncReq),
    .excVector  (excVector),
    .excCause   (excCause),
    .intEnable  (intEnable)
  );
endmodule

// File: rtl/excArbiterChecker.sv
module excArbiterChecker
  import excPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               instDone,
  input logic               fetchFault,
  input logic               pipeEmpty,
  input logic               dispatchStall,
  input logic               takeExc,
  input logic [VEC_W-1:0]   excVector,
  input logic [CAUSE_W-1:0] excCause,
  input logic               intEnable
);
  assert_take_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |=> !takeExc);

  assert_stall_in_take_R11: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |-> dispatchStall);

  assert_stall_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |=> !dispatchStall);

  assert_no_reserved_vec_R12: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |-> (excVector != 20'h00800));

  assert_enable_cleared_R10: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |-> !intEnable);

  assert_async_after_drain_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(takeExc) && ((excVector == 20'h00500) || (excVector == 20'h00900))
      |-> $past(dispatchStall) && $past(pipeEmpty));

  assert_cause_program_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    takeExc && (excVector != 20'h00700) |-> (excCause == '0));

  assert_program_has_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    takeExc && (excVector == 20'h00700) |-> (excCause != '0));

  assert_fetch_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    instDone && fetchFault && !takeExc |=> takeExc && (excVector == 20'h00400));
endmodule

bind excArbiter excArbiterChecker uChecker (
  .clk           (clk),
  .rstN          (rstN),
  .instDone      (instDone),
  .fetchFault    (fetchFault),
  .pipeEmpty     (pipeEmpty),
  .dispatchStall (dispatchStall),
  .takeExc       (takeExc),
  .excVector     (excVector),
  .excCause      (excCause),
  .intEnable     (intEnable)
);

// File: tb/tb_excArbiter.sv
module tb_excArbiter;
  localparam int CLK_PERIOD = 10;
  localparam int DEC_W = 32;

  logic clk = 1'b0;
  logic rstN;
  logic instDone, fetchFault, illegalOp, privOp, sprMove, sprNumMsb, trapHit;
  logic fpOp, userMode, fpSummary, alignFault, dataFault, pipeEmpty, extIrq, eeSet;
  logic [1:0] fpModeEn;
  logic [DEC_W-1:0] decValue;
  logic dispatchStall, takeExc, intEnable;
  logic [19:0] excVector;
  logic [3:0] excCause;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  excArbiter #(.DEC_W(DEC_W)) dut (
    .clk(clk), .rstN(rstN), .instDone(instDone), .fetchFault(fetchFault),
    .illegalOp(illegalOp), .privOp(privOp), .sprMove(sprMove), .sprNumMsb(sprNumMsb),
    .trapHit(trapHit), .fpOp(fpOp), .userMode(userMode), .fpModeEn(fpModeEn),
    .fpSummary(fpSummary), .alignFault(alignFault), .dataFault(dataFault),
    .pipeEmpty(pipeEmpty), .extIrq(extIrq), .eeSet(eeSet), .decValue(decValue),
    .dispatchStall(dispatchStall), .takeExc(takeExc), .excVector(excVector),
    .excCause(excCause), .intEnable(intEnable)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clearFaults();
    instDone = 0; fetchFault = 0; illegalOp = 0; privOp = 0; sprMove = 0;
    sprNumMsb = 0; trapHit = 0; fpOp = 0; fpSummary = 0; fpModeEn = 2'b00;
    alignFault = 0; dataFault = 0;
  endtask

  task automatic enableInts();
    eeSet = 1; step(); eeSet = 0;
    chk("R10 eeSet raises intEnable", intEnable, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rstN = 0; clearFaults(); userMode = 0; pipeEmpty = 1; extIrq = 0; eeSet = 0;
    decValue = '0;
    repeat (3) step();
    rstN = 1;
    step();
    chk("R14 takeExc", takeExc, 0);
    chk("R14 dispatchStall", dispatchStall, 0);
    chk("R14 intEnable", intEnable, 0);
    chk("R14 excVector", excVector, 0);
    chk("R14 excCause", excCause, 0);

    // sweep over every synchronous fault combination, with and without instDone
    for (int done = 0; done < 2; done++) begin
      for (int c = 0; c < 64; c++) begin
        logic f, il, pr, tr, al, da, prog;
        logic [19:0] ev;
        logic [3:0] ec;
        f = c[0]; il = c[1]; pr = c[2]; tr = c[3]; al = c[4]; da = c[5];
        prog = il | pr | tr;
        ev = 20'h0; ec = 4'h0;
        if (f) ev = 20'h00400;
        else if (prog) begin ev = 20'h00700; ec = {tr, pr, il, 1'b0}; end
        else if (al) ev = 20'h00600;
        else if (da) ev = 20'h00300;
        userMode = 1; instDone = (done == 1);
        fetchFault = f; illegalOp = il; privOp = pr; trapHit = tr;
        alignFault = al; dataFault = da;
        step();
        if (done == 0 || c == 0) begin
          chk("R2 R13 no take without fault or instDone", takeExc, 0);
        end else begin
          chk("R2 take strobe", takeExc, 1);
          chk("R1 R2 priority vector", excVector, ev);
          chk("R3 cause bits", excCause, ec);
          chk("R11 stall during strobe", dispatchStall, 1);
          // R13: faults held during the strobe cycle must not cause a second take
        end
        if (done == 0) clearFaults();
        step();
        clearFaults();
        chk("R11 R13 strobe single cycle", takeExc, 0);
        chk("R11 stall released", dispatchStall, 0);
        step();
        chk("R13 no retake", takeExc, 0);
      end
    end

    // floating-point and special-register privilege decode sweep
    for (int c = 0; c < 128; c++) begin
      logic fpF, pvF;
      fpModeEn = c[1:0]; fpSummary = c[2]; fpOp = c[3]; userMode = c[4];
      sprMove = c[5]; sprNumMsb = c[6]; instDone = 1;
      fpF = c[3] & c[2] & (c[1] | c[0]);
      pvF = c[4] & c[5] & c[6];
      step();
      clearFaults();
      chk("R4 R5 take", takeExc, fpF | pvF);
      if (fpF | pvF) begin
        chk("R4 R5 vector", excVector, 20'h00700);
        chk("R3 R4 R5 cause", excCause, {1'b0, pvF, 1'b0, fpF});
      end
      step();
    end

    // privileged opcode in supervisor mode raises nothing
    userMode = 0; instDone = 1; privOp = 1;
    step(); clearFaults();
    chk("R5 supervisor privOp ignored", takeExc, 0);
    step();

    // external interrupt with drain
    enableInts();
    extIrq = 1; pipeEmpty = 0;
    step();
    chk("R6 stall on request", dispatchStall, 1);
    chk("R6 no take before drain", takeExc, 0);
    step();
    chk("R6 still waiting", takeExc, 0);
    pipeEmpty = 1;
    step();
    chk("R6 take after drain", takeExc, 1);
    chk("R1 external vector", excVector, 20'h00500);
    chk("R3 external cause zero", excCause, 0);
    chk("R10 enable cleared on take", intEnable, 0);
    step();
    chk("R11 release after ext", dispatchStall, 0);
    step();
    chk("R10 masked ext no request", dispatchStall, 0);
    extIrq = 0;

    // synchronous fault at the end of a drain wins
    enableInts();
    extIrq = 1; pipeEmpty = 0;
    step();
    chk("R6 drain entered", dispatchStall, 1);
    pipeEmpty = 1; instDone = 1; alignFault = 1;
    step(); clearFaults();
    chk("R7 take in collision", takeExc, 1);
    chk("R7 sync wins over ext", excVector, 20'h00600);
    step(); step();
    chk("R7 ext not taken afterward", takeExc, 0);
    chk("R7 no further stall", dispatchStall, 0);
    extIrq = 0;

    // collision from idle
    enableInts();
    extIrq = 1; instDone = 1; dataFault = 1;
    step(); clearFaults();
    chk("R7 idle collision take", takeExc, 1);
    chk("R7 idle collision vector", excVector, 20'h00300);
    step(); step();
    chk("R7 idle collision no ext", takeExc | dispatchStall, 0);
    extIrq = 0;

    // take beats eeSet in the same cycle
    enableInts();
    instDone = 1; dataFault = 1; eeSet = 1;
    step(); clearFaults(); eeSet = 0;
    chk("R10 take beats eeSet", intEnable, 0);
    step();

    // timer: rise while masked, stays pending
    decValue = 32'h7fff_ffff; step();
    decValue = 32'h8000_0000; step();
    repeat (3) step();
    chk("R8 masked timer no stall", dispatchStall, 0);
    chk("R8 masked timer no take", takeExc, 0);
    extIrq = 1;
    enableInts();
    step();
    chk("R8 drain for async", dispatchStall, 1);
    step();
    chk("R8 ext ranks above timer", excVector, 20'h00500);
    chk("R8 take", takeExc, 1);
    extIrq = 0;
    step();
    enableInts();
    step();
    step();
    chk("R9 timer still pending taken", takeExc, 1);
    chk("R9 timer vector", excVector, 20'h00900);
    step();
    enableInts();
    step(); step();
    chk("R9 pending cleared after take", takeExc | dispatchStall, 0);
    chk("R8 held MSB no retrigger", intEnable, 1);
    decValue = 32'h0000_0010; step();
    decValue = 32'h8000_0005; step();
    step();
    chk("R8 fresh rise drains", dispatchStall, 1);
    step();
    chk("R8 fresh rise taken", excVector, 20'h00900);
    chk("R12 never reserved", (excVector == 20'h00800), 0);
    step();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule